// File: doc/BRIEF.md
# DMA Bus Tenure Limiter

This block decides how long a DMA engine may keep a shared system bus once an arbiter has granted it. Software or a sequencer loads a job length in words. The block then raises a bus request and waits for a grant. While it holds the bus, it counts the transfers reported by the DMA datapath. It gives the bus back when one of its release conditions is met.

A static strap input selects one of two release policies:

- **Limited policy (strap low, the default).** A tenure ends after eight transfers, or earlier if another master is asking for the bus.
- **Unlimited policy (strap high).** The engine keeps the bus until a competing master asks for it or the job runs out of words.

Any release happens only on a cycle that completes a transfer. When words remain after a release, the request stays low until the arbiter has visibly withdrawn its grant. The block then asks again, so every tenure comes from a fresh arbitration. When the last word completes, the block drops its request for good and returns to idle.

Top module: `bus_tenure_limiter`

## Requirements
- R1: A synchronous reset, asserted in any state, leaves `bus_req`, `bus_master`, `words_left` and `tenure_cnt` all zero on the next cycle.
- R2: In idle, a `job_load` with a nonzero `job_words` sets `words_left` to that value and raises `bus_req` on the next cycle. A `job_load` with `job_words` equal to zero leaves the block idle.
- R3: A `job_load` while a job is in progress is ignored, and `words_left` keeps its value.
- R4: While requesting, a high `bus_grant` makes `bus_master` high on the next cycle with `tenure_cnt` equal to 0. `bus_master` is never high without `bus_req`.
- R5: Each cycle with `xfer_done` high while `bus_master` is high decrements `words_left` by one and increments `tenure_cnt` by one. `xfer_done` has no effect while `bus_master` is low.
- R6: With `burst_unlimited` low, the eighth transfer of a tenure drops both `bus_req` and `bus_master` on the next cycle when words remain.
- R7: In either policy, `other_req` high on a cycle with `xfer_done` releases the bus on the next cycle when words remain. `other_req` without `xfer_done` does not release it.
- R8: With `burst_unlimited` high and `other_req` low, mastership is kept across any number of transfers until the job's last word.
- R9: The transfer that takes `words_left` from 1 to 0 drops `bus_req` and `bus_master` on the next cycle. No further request follows until a new job is loaded.
- R10: After a release with words remaining, `bus_req` rises again only on a cycle after `bus_grant` was sampled low. `bus_master` returns only after a new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_unlimited | input | 1 | Static strap: 0 = eight-transfer tenures, 1 = unlimited tenure |
| job_load | input | 1 | Start a job of `job_words` words (accepted only when idle) |
| job_words | input | WC_W | Job length in words |
| bus_grant | input | 1 | Grant from the bus arbiter |
| other_req | input | 1 | Another master is requesting the bus |
| xfer_done | input | 1 | One-cycle strobe per completed DMA transfer |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_master | output | 1 | The block holds the bus; the datapath may transfer |
| words_left | output | WC_W | Words still to move in the current job |
| tenure_cnt | output | CNT_W | Transfers completed in the current tenure |

## Verification
A wrong state register shows at the ports within one cycle. `bus_req` and `bus_master` are decoded directly from the state, so a missed or extra release appears as a tenure whose transfer count differs from the expected count for that policy and remaining length. A corrupted tenure counter either releases at the wrong transfer in limited mode or shows a nonzero `tenure_cnt` on the first cycle of a new tenure. A word counter that drifts shows either as a job that ends early or late against the bench's word tally, or as a request that reappears after the last word.

// File: rtl/btl_pkg.sv
package btl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_OWN  = 2'd2,
        ST_GAP  = 2'd3
    } btl_state_e;

    typedef struct packed {
        btl_state_e st;
    } btl_ctl_s;

endpackage

// File: rtl/btl_word_ctr.sv
module btl_word_ctr #(
    parameter int WC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [WC_W-1:0] load_val,
    input  logic            dec,
    output logic [WC_W-1:0] count,
    output logic            last
);
    logic [WC_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = load_val;
        end else if (dec && count_q != '0) begin
            count_d = count_q - WC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;
    assign last  = (count_q == WC_W'(1));

    // R5: every accepted transfer removes exactly one word
    p_word_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && count_q != '0) |=> (count_q == $past(count_q) - WC_W'(1)));

endmodule

// File: rtl/btl_tenure_ctr.sv
module btl_tenure_ctr #(
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = $clog2(BURST_LEN) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             limit_hit
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] SAT_VAL  = '1;

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (inc && count_q != SAT_VAL) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count     = count_q;
    assign limit_hit = (count_q == LAST_IDX);

    // R4: a cleared counter reads zero on the following cycle
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count_q == '0));

endmodule

// File: rtl/bus_tenure_limiter.sv
module bus_tenure_limiter
    import btl_pkg::*;
#(
    parameter int WC_W      = 8,
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = $clog2(BURST_LEN) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_unlimited,
    input  logic             job_load,
    input  logic [WC_W-1:0]  job_words,
    input  logic             bus_grant,
    input  logic             other_req,
    input  logic             xfer_done,
    output logic             bus_req,
    output logic             bus_master,
    output logic [WC_W-1:0]  words_left,
    output logic [CNT_W-1:0] tenure_cnt
);
    btl_ctl_s ctl_d, ctl_q;

    logic load_ok;
    logic grant_take;
    logic xfer_ok;
    logic last_word;
    logic limit_hit;
    logic yield_now;

    assign load_ok    = (ctl_q.st == ST_IDLE) && job_load && (job_words != '0);
    assign grant_take = (ctl_q.st == ST_REQ) && bus_grant;
    assign xfer_ok    = (ctl_q.st == ST_OWN) && xfer_done;
    assign yield_now  = other_req || (!burst_unlimited && limit_hit);

    btl_word_ctr #(.WC_W(WC_W)) u_words (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (job_words),
        .dec      (xfer_ok),
        .count    (words_left),
        .last     (last_word)
    );

    btl_tenure_ctr #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_tenure (
        .clk       (clk),
        .rst       (rst),
        .clear     (grant_take),
        .inc       (xfer_ok),
        .count     (tenure_cnt),
        .limit_hit (limit_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: if (load_ok)    ctl_d.st = ST_REQ;
            ST_REQ:  if (bus_grant)  ctl_d.st = ST_OWN;
            ST_OWN: begin
                if (xfer_done) begin
                    if (last_word)      ctl_d.st = ST_IDLE;
                    else if (yield_now) ctl_d.st = ST_GAP;
                end
            end
            ST_GAP:  if (!bus_grant) ctl_d.st = ST_REQ;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q.st <= ST_IDLE;
        else     ctl_q    <= ctl_d;
    end

    assign bus_req    = (ctl_q.st == ST_REQ) || (ctl_q.st == ST_OWN);
    assign bus_master = (ctl_q.st == ST_OWN);

    p_master_has_req_r4: assert property (@(posedge clk) disable iff (rst)
        bus_master |-> bus_req);

    p_grant_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_master && bus_grant) |=> bus_master);

    p_new_tenure_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_master) |-> (tenure_cnt == '0));

    p_limit_release_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_master && xfer_done && !burst_unlimited &&
         tenure_cnt == CNT_W'(BURST_LEN - 1)) |=> !bus_req);

    p_yield_release_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_master && xfer_done && other_req) |=> !bus_master);

    p_unlimited_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_master && xfer_done && burst_unlimited && !other_req &&
         words_left > WC_W'(1)) |=> bus_master);

    p_job_end_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_master && xfer_done && words_left == WC_W'(1)) |=>
        (!bus_req && words_left == '0));

    p_no_req_without_work_r9: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (words_left != '0));

    p_fresh_arbitration_r10: assert property (@(posedge clk) disable iff (rst)
        (!bus_req && words_left != '0 && bus_grant) |=> !bus_req);

endmodule

// File: tb/tb_bus_tenure_limiter.sv
`timescale 1ns/1ps
module tb_bus_tenure_limiter;
    localparam int WC_W  = 8;
    localparam int BURST = 8;
    localparam int CNT_W = $clog2(BURST) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             burst_unlimited = 1'b0;
    logic             job_load = 1'b0;
    logic [WC_W-1:0]  job_words = '0;
    logic             bus_grant = 1'b0;
    logic             other_req = 1'b0;
    logic             xfer_done = 1'b0;
    logic             bus_req;
    logic             bus_master;
    logic [WC_W-1:0]  words_left;
    logic [CNT_W-1:0] tenure_cnt;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    bus_tenure_limiter #(.WC_W(WC_W), .BURST_LEN(BURST), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .burst_unlimited(burst_unlimited),
        .job_load(job_load), .job_words(job_words), .bus_grant(bus_grant),
        .other_req(other_req), .xfer_done(xfer_done), .bus_req(bus_req),
        .bus_master(bus_master), .words_left(words_left), .tenure_cnt(tenure_cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input bit unl, input int pat, input int rem);
        int e;
        if (pat == 1)  e = (rem < 3) ? rem : 3;
        else if (unl)  e = rem;
        else           e = (rem < BURST) ? rem : BURST;
        return e;
    endfunction

    task automatic run_job(input bit unl, input int pat, input int n, input int dly);
        logic [3:0] hist = '0;
        bit p_req = 0, p_master = 0, p_grant = 0;
        int remaining = n;
        int tcount = 0;
        int rem_start = 0;
        int seen = 0;
        int cyc = 0;
        bit ended = 0;
        @(negedge clk);
        burst_unlimited = unl;
        job_load = 1'b1;
        job_words = WC_W'(n);
        @(negedge clk);
        job_load = 1'b0;
        check(bus_req == 1'b1 && words_left == WC_W'(n), "R2", int'(words_left), n);
        while (!ended && cyc < 600) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            hist = {hist[2:0], bus_req};
            if (bus_req && !p_req)
                check(p_grant == 1'b0, "R10", int'(p_grant), 0);
            if (bus_master && !p_master) begin
                check(tenure_cnt == '0, "R4", int'(tenure_cnt), 0);
                tcount = 0;
                rem_start = remaining;
            end
            if (!bus_master && p_master) begin
                if (remaining == 0) begin
                    check(tcount == exp_len(unl, pat, rem_start), "R9", tcount,
                          exp_len(unl, pat, rem_start));
                end else begin
                    check(tcount == exp_len(unl, pat, rem_start),
                          (pat == 1) ? "R7" : (unl ? "R8" : "R6"), tcount,
                          exp_len(unl, pat, rem_start));
                    check(bus_req == 1'b0, "R10", int'(bus_req), 0);
                end
            end
            if (remaining == 0 && !bus_master) begin
                xfer_done = 1'b0;
                other_req = 1'b0;
                ended = 1;
            end else begin
                bus_grant = (dly == 0) ? hist[0] : hist[2];
                case (pat)
                    1: begin xfer_done = bus_master; other_req = bus_master && tcount == 2; end
                    2: begin xfer_done = bus_master; other_req = !bus_master; end
                    3: begin xfer_done = bus_master && cyc[0]; other_req = bus_master && !xfer_done; end
                    default: begin xfer_done = bus_master; other_req = 1'b0; end
                endcase
                if (xfer_done) begin
                    tcount++;
                    remaining--;
                    seen++;
                end
                p_req = bus_req;
                p_master = bus_master;
                p_grant = bus_grant;
            end
        end
        check(ended && seen == n, "R9", seen, n);
        check(words_left == '0, "R9", int'(words_left), 0);
        for (int k = 0; k < 4; k++) begin
            hist = {hist[2:0], bus_req};
            bus_grant = (dly == 0) ? hist[0] : hist[2];
            @(negedge clk);
            check(bus_req == 1'b0, "R9", int'(bus_req), 0);
        end
        bus_grant = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int lens[9] = '{1, 2, 3, 7, 8, 9, 16, 17, 20};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(bus_req == 0 && bus_master == 0 && words_left == 0 && tenure_cnt == 0,
              "R1", int'(bus_req) + int'(bus_master), 0);

        // R2: zero-length job ignored
        job_load = 1'b1; job_words = '0;
        @(negedge clk);
        job_load = 1'b0;
        @(negedge clk);
        check(bus_req == 1'b0, "R2", int'(bus_req), 0);

        // R2: nonzero load starts a request
        job_load = 1'b1; job_words = 8'd5;
        @(negedge clk);
        job_load = 1'b0;
        check(bus_req == 1'b1 && words_left == 8'd5, "R2", int'(words_left), 5);

        // R3: reload during job ignored
        job_load = 1'b1; job_words = 8'd9;
        @(negedge clk);
        job_load = 1'b0;
        check(words_left == 8'd5, "R3", int'(words_left), 5);

        // R5: transfer strobe without mastership ignored
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check(words_left == 8'd5 && tenure_cnt == '0 && bus_master == 1'b0, "R5",
              int'(words_left), 5);

        // R4: grant gives mastership
        bus_grant = 1'b1;
        @(negedge clk);
        check(bus_master == 1'b1 && tenure_cnt == '0, "R4", int'(bus_master), 1);

        // R5: one transfer counted
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check(words_left == 8'd4 && tenure_cnt == 1, "R5", int'(words_left), 4);

        // R7: competing request without a transfer boundary keeps the bus
        other_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(bus_master == 1'b1, "R7", int'(bus_master), 1);
        other_req = 1'b0;

        // R1: reset while master
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_grant = 1'b0;
        check(bus_req == 0 && bus_master == 0 && words_left == 0 && tenure_cnt == 0,
              "R1", int'(words_left), 0);
        @(negedge clk);

        for (int u = 0; u < 2; u++)
            for (int p = 0; p < 4; p++)
                for (int d = 0; d < 2; d++)
                    for (int i = 0; i < 9; i++)
                        run_job(u[0], p, lens[i], d * 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule